// File: doc/BRIEF.md
# Headerless Register-List Loader

This block replays a list of register writes that software has placed in memory, once per video frame, into the internal register bus of a video pipeline. The list has no header. It is a plain body of entries, and each entry is a pair of 32-bit words: a register address, then the value to write there. Software describes the next list with two control registers, the body base address and the body length. It arms the list by setting an update-request bit in the same write that sets the length.

The loader only picks up an armed list at a frame boundary. When the frame-end strobe arrives with the request set and the engine idle, the loader captures base and length and clears the request bit. It then reads the body word by word through a simple request/response memory port and issues one register write per entry, in memory order. Once the bit has cleared, software is free to prepare the following list. Any attempt to change the address or length while the bit is still set is refused and recorded in a sticky error flag. A status output shows when the replay is running, and a one-cycle done pulse marks the final write.

Top module: `dlist_loader`

## Requirements
- R1: After reset, both control registers read as zero, and busy, done, err_flag, rw_valid and mem_req_valid are all low.
- R2: cfg_sel 0 selects the body base address register. cfg_sel 1 selects the size register: bits [11:0] hold the body length in bytes and bit 31 is the update-request bit. cfg_rdata combinationally returns the selected register, with the unused bits of the size register reading as zero.
- R3: When frame_end is high, the update bit is set and busy is low, the loader takes the list at that clock edge. From the next cycle the update bit reads 0.
- R4: Memory is read at base, base+4, base+8 and so on. Words alternate between register address and data. Each pair produces exactly one register write (rw_valid with rw_addr/rw_data), in memory order.
- R5: The entry count is the length shifted right by 3, so the low three length bits are ignored. The count is clamped to 256 entries.
- R6: A take with an entry count of zero clears the update bit and issues no memory read, no register write and no done pulse. busy stays low.
- R7: busy is high from the cycle after a non-empty take through the cycle of the final register write. done is high for exactly that one final-write cycle.
- R8: A CPU write to either register while the update bit is set leaves both registers unchanged and sets err_flag. err_flag stays set until reset.
- R9: A size write that sets the update bit in the same cycle as frame_end is not taken at that edge. The list is taken at the next frame_end.
- R10: A frame_end while busy is high does not take a pending list. The update bit stays set, and the list is taken at a later frame_end when idle.
- R11: A frame_end with the update bit clear has no effect: no memory read, no write, and busy stays low.
- R12: At most one memory read is outstanding. A request is held with a stable address until mem_req_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_sel | input | 1 | Register select (0 base, 1 size) |
| cfg_wdata | input | 32 | CPU write data |
| cfg_rdata | output | 32 | Selected register read-back |
| frame_end | input | 1 | One-cycle frame boundary strobe |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Byte address of word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| rw_valid | output | 1 | Internal register write strobe |
| rw_addr | output | 32 | Internal register address |
| rw_data | output | 32 | Internal register data |
| busy | output | 1 | Replay in progress |
| done | output | 1 | Pulse on final write of a list |
| err_flag | output | 1 | Sticky refused-write flag |

## Verification
Two events can meet in one clock edge: a CPU write that arms a list, and the frame-end take. The bench drives a size write with the update bit together with frame_end in the same cycle. It then expects the update bit to read back still set, with no memory activity, and the list to run only after the next frame end. The take also races with a frame end that arrives during an ongoing replay. That case is provoked by re-arming right after a take under a slow, stalling memory, and is judged by the update bit staying set and the second list's writes following the first list's writes in order.

// File: rtl/dll_pkg.sv
package dll_pkg;
   typedef enum logic [1:0] {
      FETCH_IDLE,
      FETCH_ISSUE,
      FETCH_WAIT
   } fetch_st_e;

   localparam logic REG_BASE   = 1'b0;
   localparam logic REG_SIZE   = 1'b1;
   localparam int   ENTRY_SHIFT = 3;
   localparam int   WORD_BYTES  = 4;
endpackage

// File: rtl/dll_regs.sv
module dll_regs #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              take,
   output logic [ADDR_W-1:0] base_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              upd_o,
   output logic              err_o,
   output logic [WORD_W-1:0] cfg_rdata
);
   import dll_pkg::*;

   localparam int UPD_BIT = WORD_W - 1;
   localparam int PAD_W   = WORD_W - 1 - LEN_W;

   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic              upd_q;
   logic              err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= '0;
         upd_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (take) begin
            upd_q <= 1'b0;
         end
         if (cfg_we) begin
            if (upd_q) begin
               err_q <= 1'b1;
            end else if (cfg_sel == REG_BASE) begin
               base_q <= cfg_wdata[ADDR_W-1:0];
            end else begin
               len_q <= cfg_wdata[LEN_W-1:0];
               upd_q <= cfg_wdata[UPD_BIT];
            end
         end
      end
   end

   always_comb begin
      if (cfg_sel == REG_BASE) begin
         cfg_rdata = WORD_W'(base_q);
      end else begin
         cfg_rdata = {upd_q, {PAD_W{1'b0}}, len_q};
      end
   end

   assign base_o = base_q;
   assign len_o  = len_q;
   assign upd_o  = upd_q;
   assign err_o  = err_q;

   // R8: refused writes leave the list description untouched
   a_r8_locked_regs: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && upd_q) |=> ($stable(base_q) && $stable(len_q) && err_q));

   // R8: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/dll_fetch.sv
module dll_fetch #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_base,
   input  logic [CNT_W-1:0]  start_cnt,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic              word_odd,
   output logic              word_last,
   output logic              active
);
   import dll_pkg::*;

   localparam int LEFT_W = CNT_W + 1;

   fetch_st_e         st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEFT_W-1:0] left_q;
   logic              odd_q;
   logic              last_word;

   assign last_word = (left_q == LEFT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= FETCH_IDLE;
         addr_q <= '0;
         left_q <= '0;
         odd_q  <= 1'b0;
      end else begin
         unique case (st_q)
            FETCH_IDLE: begin
               if (start && (start_cnt != '0)) begin
                  addr_q <= start_base;
                  left_q <= {start_cnt, 1'b0};
                  odd_q  <= 1'b0;
                  st_q   <= FETCH_ISSUE;
               end
            end
            FETCH_ISSUE: begin
               if (mem_req_ready) begin
                  st_q <= FETCH_WAIT;
               end
            end
            FETCH_WAIT: begin
               if (mem_rsp_valid) begin
                  addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                  left_q <= left_q - LEFT_W'(1);
                  odd_q  <= ~odd_q;
                  st_q   <= last_word ? FETCH_IDLE : FETCH_ISSUE;
               end
            end
            default: st_q <= FETCH_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (st_q == FETCH_ISSUE);
   assign mem_req_addr  = addr_q;
   assign word_valid    = (st_q == FETCH_WAIT) && mem_rsp_valid;
   assign word_data     = mem_rsp_data;
   assign word_odd      = odd_q;
   assign word_last     = last_word;
   assign active        = (st_q != FETCH_IDLE);

   // R12: a request is held with a stable address until accepted
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R12: no new request while a response is still awaited
   a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R4: consecutive reads step by one word
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_last) |=> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/dll_replay.sv
module dll_replay #(
   parameter int WORD_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_odd,
   input  logic              word_last,
   output logic              rw_valid,
   output logic [WORD_W-1:0] rw_addr,
   output logic [WORD_W-1:0] rw_data,
   output logic              done,
   output logic              pend
);
   logic [WORD_W-1:0] ra_q;
   logic              fire;

   assign fire = word_valid && word_odd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ra_q <= '0;
      end else if (word_valid && !word_odd) begin
         ra_q <= word_data;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic              v_q;
         logic              d_q;
         logic [WORD_W-1:0] a_q;
         logic [WORD_W-1:0] w_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= 1'b0;
               a_q <= '0;
               w_q <= '0;
            end else begin
               v_q <= fire;
               d_q <= fire && word_last;
               if (fire) begin
                  a_q <= ra_q;
                  w_q <= word_data;
               end
            end
         end

         assign rw_valid = v_q;
         assign rw_addr  = a_q;
         assign rw_data  = w_q;
         assign done     = d_q;
         assign pend     = v_q;
      end else begin : g_out_comb
         assign rw_valid = fire;
         assign rw_addr  = ra_q;
         assign rw_data  = word_data;
         assign done     = fire && word_last;
         assign pend     = 1'b0;
      end
   endgenerate

   // R4: the final word of a list is always a data word
   a_r4_last_is_data: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_last) |-> word_odd);
endmodule

// File: rtl/dlist_loader.sv
module dlist_loader #(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int MAX_ENTRIES = 256,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   input  logic              frame_end,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_data,
   output logic              rw_valid,
   output logic [WORD_W-1:0] rw_addr,
   output logic [WORD_W-1:0] rw_data,
   output logic              busy,
   output logic              done,
   output logic              err_flag
);
   import dll_pkg::*;

   localparam int LEN_W = $clog2(MAX_ENTRIES * 8) + 1;
   localparam int CNT_W = LEN_W - ENTRY_SHIFT;

   generate
      if (MAX_ENTRIES < 1) begin : g_bad_depth
         $error("MAX_ENTRIES must be at least 1");
      end
      if (ADDR_W > WORD_W) begin : g_bad_addr
         $error("ADDR_W must not exceed WORD_W");
      end
      if (LEN_W > WORD_W - 2) begin : g_bad_len
         $error("length field does not fit the size register");
      end
      if (WORD_W < 8) begin : g_bad_word
         $error("WORD_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [LEN_W-1:0]  len;
   logic              upd;
   logic              take;
   logic [CNT_W-1:0]  raw_cnt;
   logic [CNT_W-1:0]  cnt;
   logic [ENTRY_SHIFT-1:0] unused_len_lsb;

   logic              w_valid;
   logic [WORD_W-1:0] w_data;
   logic              w_odd;
   logic              w_last;
   logic              f_active;
   logic              r_pend;

   assign raw_cnt        = len[LEN_W-1:ENTRY_SHIFT];
   assign unused_len_lsb = len[ENTRY_SHIFT-1:0];
   assign cnt            = (raw_cnt > CNT_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES) : raw_cnt;
   assign take           = frame_end && upd && !busy;
   assign busy           = f_active || r_pend;

   dll_regs #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .LEN_W  (LEN_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .take      (take),
      .base_o    (base),
      .len_o     (len),
      .upd_o     (upd),
      .err_o     (err_flag),
      .cfg_rdata (cfg_rdata)
   );

   dll_fetch #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) fetch_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (take),
      .start_base    (base),
      .start_cnt     (cnt),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .word_valid    (w_valid),
      .word_data     (w_data),
      .word_odd      (w_odd),
      .word_last     (w_last),
      .active        (f_active)
   );

   dll_replay #(
      .WORD_W  (WORD_W),
      .OUT_REG (OUT_REG)
   ) replay_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (w_valid),
      .word_data  (w_data),
      .word_odd   (w_odd),
      .word_last  (w_last),
      .rw_valid   (rw_valid),
      .rw_addr    (rw_addr),
      .rw_data    (rw_data),
      .done       (done),
      .pend       (r_pend)
   );

   // R3: a take clears the request bit
   a_r3_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && upd && !busy) |=> !upd);

   // R10: a frame end during replay leaves the request pending
   a_r10_busy_defers: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && upd && busy) |=> upd);

   // R7: done only accompanies a register write while busy
   a_r7_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rw_valid && busy));

   // R6: no memory traffic while idle
   a_r6_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> busy);
endmodule

// File: tb/dlist_loader_tb_top.sv
module dlist_loader_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        frame_end = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rw_valid;
   logic [31:0] rw_addr;
   logic [31:0] rw_data;
   logic        busy;
   logic        done;
   logic        err_flag;

   localparam logic [31:0] UPD = 32'h8000_0000;

   always #4 clk = ~clk;

   dlist_loader dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_end(frame_end),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rw_valid(rw_valid), .rw_addr(rw_addr),
      .rw_data(rw_data), .busy(busy), .done(done), .err_flag(err_flag)
   );

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int done_cnt = 0;
   int rd_cnt = 0;
   int lat = 1;
   bit stall = 1'b0;
   bit finished = 1'b0;
   logic [31:0] exp_rd_addr = '0;
   logic [63:0] exp_q[$];
   logic [31:0] mem_model[logic [31:0]];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // memory model: one outstanding read, latency lat, optional stalls
   initial begin
      int cyc = 0;
      int left = 0;
      logic [31:0] a = '0;
      forever begin
         @(negedge clk);
         cyc++;
         mem_rsp_valid = 1'b0;
         if (left > 0) begin
            mem_req_ready = 1'b0;
            left--;
            if (left == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = mem_model.exists(a) ? mem_model[a] : 32'hDEAD_BEEF;
            end
         end else begin
            mem_req_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (mem_req_valid && mem_req_ready) begin
               a = mem_req_addr;
               chk(a == exp_rd_addr, "R4", "read address", a, exp_rd_addr);
               exp_rd_addr = exp_rd_addr + 32'd4;
               rd_cnt++;
               left = lat;
            end
         end
      end
   end

   // scoreboard monitor
   initial begin
      logic [63:0] e;
      forever begin
         @(negedge clk);
         if (rw_valid) begin
            wr_cnt++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected write addr", rw_addr, 32'h0);
            end else begin
               e = exp_q.pop_front();
               chk(rw_addr == e[63:32], "R4", "write address", rw_addr, e[63:32]);
               chk(rw_data == e[31:0], "R4", "write data", rw_data, e[31:0]);
            end
         end
         if (done) begin
            done_cnt++;
            chk(rw_valid, "R7", "done without write", 32'(rw_valid), 32'h1);
            chk(exp_q.size() == 0, "R7", "entries left at done", 32'(exp_q.size()), 32'h0);
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         report();
      end
   end

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic sel, output logic [31:0] v);
      @(negedge clk);
      cfg_sel = sel;
      #1 v = cfg_rdata;
   endtask

   task automatic pulse_fe();
      @(negedge clk);
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
   endtask

   task automatic arm_with_fe(input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = d; frame_end = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; frame_end = 1'b0;
   endtask

   // driver: builds a body in memory and pushes expected writes
   task automatic load_list(input logic [31:0] base, input int n);
      int ne;
      logic [31:0] a;
      logic [31:0] d;
      ne = (n > 256) ? 256 : n;
      for (int k = 0; k < ne; k++) begin
         a = 32'h0040_0000 + base + 32'(k * 4);
         d = {base[15:0], 16'(k)} ^ 32'hA5A5_0000;
         mem_model[base + 32'(8 * k)]     = a;
         mem_model[base + 32'(8 * k + 4)] = d;
         exp_q.push_back({a, d});
      end
      exp_rd_addr = base;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      logic [31:0] v;
      int w0, d0, r0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cfg_read(1'b0, v);
      chk(v == 32'h0, "R1", "base after reset", v, 32'h0);
      cfg_read(1'b1, v);
      chk(v == 32'h0, "R1", "size after reset", v, 32'h0);
      chk({busy, done, err_flag, rw_valid, mem_req_valid} == 5'b0, "R1", "status after reset",
          32'({busy, done, err_flag, rw_valid, mem_req_valid}), 32'h0);

      // R2, R3, R4, R7 basic three-entry list
      cfg_write(1'b0, 32'h0000_0100);
      cfg_write(1'b1, UPD | 32'd24);
      cfg_read(1'b1, v);
      chk(v == (UPD | 32'd24), "R2", "size readback", v, UPD | 32'd24);
      cfg_read(1'b0, v);
      chk(v == 32'h100, "R2", "base readback", v, 32'h100);
      load_list(32'h100, 3);
      w0 = wr_cnt; d0 = done_cnt;
      pulse_fe();
      chk(busy, "R7", "busy after take", 32'(busy), 32'h1);
      cfg_read(1'b1, v);
      chk(v == 32'd24, "R3", "update cleared by take", v, 32'd24);
      wait_idle();
      chk(wr_cnt - w0 == 3, "R4", "write count", 32'(wr_cnt - w0), 32'd3);
      chk(done_cnt - d0 == 1, "R7", "one done pulse", 32'(done_cnt - d0), 32'd1);

      // R8 refused writes while armed
      cfg_write(1'b0, 32'h0000_0400);
      cfg_write(1'b1, UPD | 32'd16);
      chk(!err_flag, "R8", "no error on legal writes", 32'(err_flag), 32'h0);
      cfg_write(1'b0, 32'h0000_0999);
      cfg_read(1'b0, v);
      chk(v == 32'h400, "R8", "base kept while armed", v, 32'h400);
      chk(err_flag, "R8", "error flag set", 32'(err_flag), 32'h1);
      cfg_write(1'b1, 32'd8);
      cfg_read(1'b1, v);
      chk(v == (UPD | 32'd16), "R8", "size kept while armed", v, UPD | 32'd16);
      load_list(32'h400, 2);
      w0 = wr_cnt;
      pulse_fe();
      wait_idle();
      chk(wr_cnt - w0 == 2, "R8", "armed list still runs", 32'(wr_cnt - w0), 32'd2);
      chk(err_flag, "R8", "error flag sticky", 32'(err_flag), 32'h1);

      // R9 arming in the frame-end cycle is taken one frame later
      cfg_write(1'b0, 32'h0000_0800);
      w0 = wr_cnt; r0 = rd_cnt;
      arm_with_fe(UPD | 32'd32);
      cfg_read(1'b1, v);
      chk(v == (UPD | 32'd32), "R9", "late arm not taken", v, UPD | 32'd32);
      repeat (6) @(negedge clk);
      chk(!busy && rd_cnt == r0 && wr_cnt == w0, "R9", "no activity before next frame",
          32'(rd_cnt - r0), 32'h0);
      load_list(32'h800, 4);
      pulse_fe();
      wait_idle();
      chk(wr_cnt - w0 == 4, "R9", "taken at next frame end", 32'(wr_cnt - w0), 32'd4);

      // R6 zero-length list
      w0 = wr_cnt; d0 = done_cnt; r0 = rd_cnt;
      cfg_write(1'b1, UPD);
      pulse_fe();
      chk(!busy, "R6", "busy stays low", 32'(busy), 32'h0);
      cfg_read(1'b1, v);
      chk(v == 32'h0, "R6", "update cleared", v, 32'h0);
      repeat (5) @(negedge clk);
      chk(rd_cnt == r0 && wr_cnt == w0 && done_cnt == d0, "R6", "no traffic",
          32'(rd_cnt - r0 + wr_cnt - w0 + done_cnt - d0), 32'h0);

      // R11 frame end without request
      r0 = rd_cnt; w0 = wr_cnt;
      pulse_fe();
      chk(!busy, "R11", "no busy", 32'(busy), 32'h0);
      repeat (5) @(negedge clk);
      chk(rd_cnt == r0 && wr_cnt == w0, "R11", "no traffic", 32'(rd_cnt - r0), 32'h0);

      // R10, R12 frame end during replay, stalling slow memory
      stall = 1'b1; lat = 3;
      cfg_write(1'b0, 32'h0000_1000);
      cfg_write(1'b1, UPD | 32'd40);
      load_list(32'h1000, 5);
      w0 = wr_cnt;
      pulse_fe();
      cfg_write(1'b0, 32'h0000_2000);
      cfg_write(1'b1, UPD | 32'd16);
      chk(busy, "R10", "still replaying", 32'(busy), 32'h1);
      pulse_fe();
      cfg_read(1'b1, v);
      chk(v == (UPD | 32'd16), "R10", "request kept during replay", v, UPD | 32'd16);
      wait_idle();
      chk(wr_cnt - w0 == 5, "R12", "first list under stalls", 32'(wr_cnt - w0), 32'd5);
      load_list(32'h2000, 2);
      pulse_fe();
      wait_idle();
      chk(wr_cnt - w0 == 7, "R10", "deferred list taken later", 32'(wr_cnt - w0), 32'd7);

      // R5 clamp to 256 entries, low bits ignored
      stall = 1'b0; lat = 1;
      cfg_write(1'b0, 32'h0001_0000);
      cfg_write(1'b1, UPD | 32'h965);
      cfg_read(1'b1, v);
      chk(v == (UPD | 32'h965), "R2", "raw length readback", v, UPD | 32'h965);
      load_list(32'h0001_0000, 300);
      w0 = wr_cnt; r0 = rd_cnt;
      pulse_fe();
      wait_idle();
      chk(wr_cnt - w0 == 256, "R5", "clamped entry count", 32'(wr_cnt - w0), 32'd256);
      chk(rd_cnt - r0 == 512, "R5", "clamped read count", 32'(rd_cnt - r0), 32'd512);

      // R5 length not a multiple of eight
      cfg_write(1'b0, 32'h0000_3000);
      cfg_write(1'b1, UPD | 32'd19);
      load_list(32'h3000, 2);
      w0 = wr_cnt;
      pulse_fe();
      wait_idle();
      chk(wr_cnt - w0 == 2, "R5", "low length bits ignored", 32'(wr_cnt - w0), 32'd2);

      repeat (3) @(negedge clk);
      report();
   end
endmodule